// File: doc/BRIEF.md
# Three-Stage Half-Band Interpolator

This block raises the sample rate of one 12-bit data channel by 1, 2, 4 or 8 through a cascade of up to three fixed half-band FIR stages. Everything runs on a single fast clock at the output rate. Each input sample is marked by a one-cycle valid strobe, and the strobes arrive once every 2^r cycles, where r is the rate code. Every active stage doubles the rate. The output valid is high in every cycle once the chain is filled.

Two options change how the chain behaves. The first accepts offset-binary input in place of two's complement. The second turns each active stage into plain zero insertion, which leaves one zero between each pair of samples with no filtering. Each stage scales its filtered phase back to unity DC gain, rounds to nearest and clamps to the 16-bit internal width. The 12-bit input sits in the upper bits of that 16-bit word. The rate code and the options are static while reset is low. They are changed only while reset is held.

Top module: `hb_interp_chain`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0 and out_data is 0.
- R2: With rate_sel = 00 every stage is bypassed. A sample strobed at clock edge t appears on out_valid/out_data after edge t+1, equal to the input shifted left by 4 (12-bit value in bits 15:4, bits 3:0 zero).
- R3: With bin_offset = 1, input bit 11 is inverted before any other processing, so 0x800 maps to zero. With bin_offset = 0 the input is taken as two's complement.
- R4: With rate_sel = 01, only the 43-tap stage runs. For input x[n] it emits two outputs. The first is the side-tap sum over x[n]..x[n-21] with weights 8, -29, 67, -134, 244, -414, 673, -1079, 1772, -3280, 10364, 10364, -3280, ... 8, divided by 2^14. The second is x[n-10] unchanged.
- R5: With rate_sel = 10, the 43-tap stage feeds a 19-tap stage. That stage uses side weights 19, -120, 438, -1288, 5047 (mirrored over 10 samples) divided by 2^13, and a centre phase of x[n-4].
- R6: With rate_sel = 11, a third 11-tap stage follows. It uses side weights 7, -53, 302 (mirrored over 6 samples) divided by 2^9, and a centre phase of x[n-2].
- R7: Each side-tap sum is rounded by adding half an LSB and shifting right arithmetically. The result is then clamped to the range -32768..32767.
- R8: With stuff_zero = 1, each active stage emits its input sample and then a 0, and does no filtering.
- R9: With strobes every 2^r cycles, each input gives exactly 2^r outputs. The outputs of a run come on consecutive clock cycles with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at the output sample rate |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Interpolation factor code: 00 x1, 01 x2, 10 x4, 11 x8 |
| stuff_zero | input | 1 | 1 selects plain zero insertion in every active stage |
| bin_offset | input | 1 | 1 selects offset-binary input coding |
| in_valid | input | 1 | Input sample strobe, once every 2^rate_sel cycles |
| in_data | input | 12 | Input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Output sample, two's complement |

## Verification
The hardest overlap happens inside each stage. The valid strobe of a new input and the emission of the previous input's delayed centre phase fall in neighbouring cycles. At 8x, the first stage's next sample lands in the same cycle in which the later stages are still sending out the earlier outputs. A gap, a duplicate or a wrong phase order would break the continuous output stream. Random data at all four rates is run back to back with no idle time. The captured stream is compared sample by sample with a convolution of the zero-stuffed input against the full tap set, and the first-to-last cycle span must equal the sample count. Full-scale steps push the filtered phase past the clamp limits in the same runs.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int IN_W    = 12;
    localparam int OUT_W   = 16;
    localparam int ACC_W   = 40;
    localparam int NUM_STG = 3;
    localparam int PAD_W   = OUT_W - IN_W;

    typedef logic signed [OUT_W-1:0] smp_t;

    typedef struct packed {
        logic vld;
        smp_t dat;
    } strm_t;

    // number of distinct nonzero side weights per stage
    function automatic int side_cnt(input int s);
        case (s)
            0:       return 11;
            1:       return 5;
            default: return 3;
        endcase
    endfunction

    // power of two held by the centre tap
    function automatic int shift_of(input int s);
        case (s)
            0:       return 14;
            1:       return 13;
            default: return 9;
        endcase
    endfunction

    // side weight k (0 = outermost) of stage s
    function automatic int tap(input int s, input int k);
        int w;
        w = 0;
        if (s == 0) begin
            case (k)
                0: w = 8;     1: w = -29;   2: w = 67;    3: w = -134;
                4: w = 244;   5: w = -414;  6: w = 673;   7: w = -1079;
                8: w = 1772;  9: w = -3280; 10: w = 10364;
                default: w = 0;
            endcase
        end else if (s == 1) begin
            case (k)
                0: w = 19;    1: w = -120;  2: w = 438;   3: w = -1288;
                4: w = 5047;
                default: w = 0;
            endcase
        end else begin
            case (k)
                0: w = 7;     1: w = -53;   2: w = 302;
                default: w = 0;
            endcase
        end
        return w;
    endfunction

    function automatic smp_t fmt_in(input logic [IN_W-1:0] raw, input logic ubin);
        logic [IN_W-1:0] t;
        t = raw;
        t[IN_W-1] = raw[IN_W-1] ^ ubin;
        return smp_t'({t, {PAD_W{1'b0}}});
    endfunction

    function automatic smp_t round_sat(input logic signed [ACC_W-1:0] acc, input int sh);
        logic signed [ACC_W-1:0] bias;
        logic signed [ACC_W-1:0] q;
        logic signed [ACC_W-1:0] hi;
        logic signed [ACC_W-1:0] lo;
        bias = {{(ACC_W-1){1'b0}}, 1'b1} << (sh - 1);
        q    = (acc + bias) >>> sh;
        hi   = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
        lo   = ~hi;
        if (q > hi)      return smp_t'(hi[OUT_W-1:0]);
        else if (q < lo) return smp_t'(lo[OUT_W-1:0]);
        else             return smp_t'(q[OUT_W-1:0]);
    endfunction
endpackage

// File: rtl/hb_stage.sv
module hb_stage
    import hb_pkg::*;
#(
    parameter int STG = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       zstuff,
    input  logic [3:0] half,
    input  strm_t      in_s,
    output strm_t      out_s
);
    localparam int NS  = side_cnt(STG);
    localparam int WN  = 2 * NS;
    localparam int DL  = WN - 1;
    localparam int SH  = shift_of(STG);
    localparam int MID = NS - 1;

    smp_t dl  [DL];
    smp_t win [WN];
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] pre;
    smp_t ph_a;
    smp_t ph_b;
    logic go;
    logic pend;
    logic [3:0] cnt;

    assign go = active & in_s.vld;

    always_comb begin
        win[0] = in_s.dat;
        for (int k = 1; k < WN; k++) win[k] = dl[k-1];
    end

    // symmetric pre-add, one multiply per distinct weight
    always_comb begin
        acc = '0;
        pre = '0;
        for (int k = 0; k < NS; k++) begin
            pre = {{(ACC_W-OUT_W){win[k][OUT_W-1]}}, win[k]}
                + {{(ACC_W-OUT_W){win[WN-1-k][OUT_W-1]}}, win[WN-1-k]};
            acc = acc + pre * ACC_W'(tap(STG, k));
        end
    end

    assign ph_a = zstuff ? in_s.dat : round_sat(acc, SH);
    assign ph_b = zstuff ? smp_t'('0) : dl[MID];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DL; k++) dl[k] <= '0;
            out_s <= '0;
            pend  <= 1'b0;
            cnt   <= '0;
        end else if (go) begin
            dl[0] <= in_s.dat;
            for (int k = 1; k < DL; k++) dl[k] <= dl[k-1];
            out_s <= '{vld: 1'b1, dat: ph_a};
            pend  <= 1'b1;
            cnt   <= half - 4'd1;
        end else if (pend && cnt == 4'd0) begin
            out_s <= '{vld: 1'b1, dat: ph_b};
            pend  <= 1'b0;
        end else begin
            out_s.vld <= 1'b0;
            if (pend) cnt <= cnt - 4'd1;
        end
    end
endmodule

// File: rtl/hb_interp_chain.sv
module hb_interp_chain
    import hb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        rate_sel,
    input  logic              stuff_zero,
    input  logic              bin_offset,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);
    strm_t      lnk    [NUM_STG+1];
    logic       act    [NUM_STG];
    logic [3:0] half_v [NUM_STG];
    strm_t      sel;

    always_ff @(posedge clk) begin
        if (rst) lnk[0] <= '0;
        else     lnk[0] <= '{vld: in_valid, dat: fmt_in(in_data, bin_offset)};
    end

    for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
        assign act[s]    = (rate_sel > 2'(s));
        assign half_v[s] = act[s] ? (4'd1 << (rate_sel - 2'(s + 1))) : 4'd1;
        hb_stage #(.STG(s)) u_stg (
            .clk    (clk),
            .rst    (rst),
            .active (act[s]),
            .zstuff (stuff_zero),
            .half   (half_v[s]),
            .in_s   (lnk[s]),
            .out_s  (lnk[s+1])
        );
    end

    assign sel = lnk[rate_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= sel.vld;
            if (sel.vld) out_data <= sel.dat;
        end
    end
endmodule

// File: rtl/hb_interp_chain_chk.sv
module hb_interp_chain_chk
    import hb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       rate_sel,
    input logic             stuff_zero,
    input logic             bin_offset,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_data,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        // R1
        if (rst_q) begin
            reset_quiet_chk: assert (!out_valid && out_data == '0)
                else $error("outputs active right after reset");
        end
    end

    // R2
    pass_val_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 2'd0 && in_valid) |=> ##1
        (out_valid && out_data == fmt_in($past(in_data, 2), bin_offset)));

    // R2
    pass_src_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 2'd0 && out_valid) |-> $past(in_valid, 2));

    // R8
    stuff_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 2'd1 && stuff_zero && in_valid) |=> ##2
        (out_valid && out_data == fmt_in($past(in_data, 3), bin_offset)) ##1
        (out_valid && out_data == '0));
endmodule

bind hb_interp_chain hb_interp_chain_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rate_sel   (rate_sel),
    .stuff_zero (stuff_zero),
    .bin_offset (bin_offset),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/hb_interp_chain_test.sv
module hb_interp_chain_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  rate_sel = 2'd0;
    logic        stuff_zero = 1'b0;
    logic        bin_offset = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit cap_en = 0;
    int cyc    = 0;
    int first_c, last_c;
    int cap [$];
    int mq  [$];

    always #10 clk = ~clk;

    hb_interp_chain uut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .stuff_zero(stuff_zero),
        .bin_offset(bin_offset), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always @(negedge clk) begin
        cyc++;
        if (cap_en && out_valid) begin
            if (cap.size() == 0) first_c = cyc;
            last_c = cyc;
            cap.push_back(int'($signed(out_data)));
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int coef_b(input int s, input int i);
        int a0 [11] = '{8, -29, 67, -134, 244, -414, 673, -1079, 1772, -3280, 10364};
        int a1 [5]  = '{19, -120, 438, -1288, 5047};
        int a2 [3]  = '{7, -53, 302};
        if (s == 0) return a0[i];
        if (s == 1) return a1[i];
        return a2[i];
    endfunction

    function automatic int nside_b(input int s);
        return (s == 0) ? 11 : (s == 1) ? 5 : 3;
    endfunction

    function automatic int sh_b(input int s);
        return (s == 0) ? 14 : (s == 1) ? 13 : 9;
    endfunction

    function automatic int hfull(input int s, input int t);
        int L, c, m, i;
        L = 4 * nside_b(s) - 1;
        c = (L - 1) / 2;
        if (t == c) return 1 << sh_b(s);
        if (t % 2 != 0) return 0;
        i = t / 2;
        m = (L - 1 - t) / 2;
        return coef_b(s, (i < m) ? i : m);
    endfunction

    // zero-stuff then full convolution, round half up, clamp
    task automatic model_stage(input int s, input bit zs);
        int tmp [$];
        int L, sh;
        longint acc;
        L  = 4 * nside_b(s) - 1;
        sh = sh_b(s);
        for (int j = 0; j < 2 * mq.size(); j++) begin
            if (zs) begin
                tmp.push_back((j % 2 == 0) ? mq[j/2] : 0);
            end else begin
                acc = 0;
                for (int t = 0; t < L; t++)
                    if (j - t >= 0 && (j - t) % 2 == 0)
                        acc += longint'(hfull(s, t)) * longint'(mq[(j-t)/2]);
                acc = (acc + (longint'(1) << (sh - 1))) >>> sh;
                if (acc > 32767) acc = 32767;
                if (acc < -32768) acc = -32768;
                tmp.push_back(int'(acc));
            end
        end
        mq = tmp;
    endtask

    function automatic int conv_b(input logic [11:0] raw, input bit ub);
        logic [11:0] v;
        v = ub ? (raw ^ 12'h800) : raw;
        return int'($signed(v)) * 16;
    endfunction

    // mode 0 random, 1 impulse, 2 rising full-scale step, 3 falling step
    task automatic run_case(input int r, input bit zs, input bit ub, input int mode,
                            input int n, input string tag);
        int R;
        logic [11:0] s;
        R = 1 << r;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        rate_sel = 2'(r); stuff_zero = zs; bin_offset = ub;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_data == 16'd0, "R1 reset state", int'(out_data), 0);
        rst = 1'b0;
        cap.delete(); mq.delete();
        cap_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            case (mode)
                1:       s = (k == 0) ? 12'h7FF : 12'h000;
                2:       s = (k < n/2) ? 12'h800 : 12'h7FF;
                3:       s = (k < n/2) ? 12'h7FF : 12'h800;
                default: s = 12'($urandom);
            endcase
            if (ub && mode != 0) s = s ^ 12'h800;
            in_valid = 1'b1;
            in_data  = s;
            mq.push_back(conv_b(s, ub));
            @(negedge clk);
            for (int w = 1; w < R; w++) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        repeat (40) @(negedge clk);
        cap_en = 1'b0;
        for (int s2 = 0; s2 < r; s2++) model_stage(s2, zs);
        chk(cap.size() == mq.size(), "R9 output count", cap.size(), mq.size());
        chk(cap.size() == 0 || (last_c - first_c + 1) == cap.size(),
            "R9 gapless cadence", last_c - first_c + 1, cap.size());
        for (int k = 0; k < mq.size() && k < cap.size(); k++)
            chk(cap[k] == mq[k], tag, cap[k], mq[k]);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        run_case(0, 0, 0, 0, 24, "R2 bypass data");
        run_case(0, 0, 1, 0, 24, "R3 offset-binary bypass");
        run_case(1, 0, 0, 1, 16, "R4 impulse x2");
        run_case(1, 0, 0, 0, 24, "R4 random x2");
        run_case(1, 0, 1, 0, 24, "R3 offset-binary x2");
        run_case(2, 0, 0, 0, 24, "R5 random x4");
        run_case(2, 0, 0, 1, 16, "R5 impulse x4");
        run_case(3, 0, 0, 0, 24, "R6 random x8");
        run_case(3, 0, 0, 2, 24, "R7 rising step clamp");
        run_case(1, 0, 0, 3, 24, "R7 falling step clamp");
        run_case(1, 1, 0, 0, 24, "R8 zero insert x2");
        run_case(3, 1, 1, 0, 16, "R8 zero insert x8");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule